// File: doc/BRIEF.md
# Down-Counting Timer with APB Register Access

This block is a single programmable timer channel that sits on an APB bus as a slave. Software writes a 32-bit reload value and a small control word. Once enabled, a 32-bit counter steps down by one on every clock. At each terminal count the counter reloads. In periodic mode it reloads the programmed value. In free-running mode it reloads all ones. Software can read the live count at any time, and the bitwise inverse of that count gives elapsed ticks.

Each step from one to zero sets a raw interrupt flag. The flag stays set until software reads one of the two end-of-interrupt locations. A mask bit in the control word hides the flag from the interrupt output and from the masked status views. The raw view still reports it. Global locations repeat the status views, the interrupt clear and a fixed version word.

The bus never stalls and never signals an error. All bus-visible state returns to zero while the active-low reset is held.

Top module: `apb_cdtimer`

## Requirements
- R1: While reset is low and just after it is released, the load, current value, control and raw status registers all read 0 and `irq` is low.
- R2: The register map is as follows. Offset 0x00 holds the load value, which can be written and read. Offset 0x08 holds the control word in bits [2:0]: bit 0 enables the counter, bit 1 selects periodic mode when 1, and bit 2 is the mask. Bits above [2:0] of the control word read as 0. Offset 0xAC returns the VERSION parameter. Any offset that is not mapped reads 0.
- R3: A control write that takes enable from 0 to 1 copies the load value into the counter on that write's clock edge. After that edge the counter decrements by one on every clock while it is enabled. Offset 0x04 reads the counter.
- R4: While enable is 0 the counter holds its value and no new interrupt is raised. Clearing enable leaves an interrupt that is already pending still pending.
- R5: The raw flag sets on the edge where the counter steps from 1 to 0, whatever the mask bit is set to. Bit 0 of offset 0xA8 reads the raw flag.
- R6: In periodic mode the counter reloads the load value on the edge after it reaches 0. A load value L therefore gives an interrupt every L+1 cycles.
- R7: In free-running mode the counter reloads 0xFFFF_FFFF on the edge after it reaches 0.
- R8: A read of offset 0x0C or offset 0xA4 returns 0 and clears the raw flag. If a terminal step falls on the same edge as such a read, the flag stays set.
- R9: Bit 0 of offsets 0x10 and 0xA0 reads the raw flag ANDed with the inverse of the mask. `irq` carries the same value.
- R10: Writes to the read-only offsets (0x04, 0x0C, 0x10, 0xA0, 0xA4, 0xA8 and 0xAC) change no state.
- R11: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Masked interrupt, high while pending and unmasked |

## Verification
The hardest case to reach is an end-of-interrupt read whose access edge lands on the same edge as a terminal step, because the clear and the new set then compete. The bench keeps a free-running cycle count and records the edge on which the enabling write lands. From that count it predicts the edge of the second periodic terminal step. It then starts the clearing read exactly three edges earlier, so that its access phase ends on that edge. The counter values it expects after a stop are computed the same way, from the number of edges between the enabling write and the disabling write, with the period wrap or the free-running wrap applied.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // byte offsets that software depends on
  localparam logic [7:0] OFS_LOAD  = 8'h00;
  localparam logic [7:0] OFS_CUR   = 8'h04;
  localparam logic [7:0] OFS_CTL   = 8'h08;
  localparam logic [7:0] OFS_EOI   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_GSTAT = 8'hA0;
  localparam logic [7:0] OFS_GEOI  = 8'hA4;
  localparam logic [7:0] OFS_GRAW  = 8'hA8;
  localparam logic [7:0] OFS_VER   = 8'hAC;

  localparam int unsigned CTL_W  = 3;
  localparam int unsigned CB_EN  = 0;

  // packed so that bit 0 = enable, bit 1 = periodic, bit 2 = mask
  typedef struct packed {
    logic msk;
    logic per;
    logic en;
  } ctl_t;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_LOAD,
    RS_CUR,
    RS_CTL,
    RS_MSTAT,
    RS_RAW,
    RS_VER
  } rsel_e;

endpackage

// File: rtl/tmr_apb_dec.sv
module tmr_apb_dec
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              wr_load,
  output logic              wr_ctl,
  output logic              eoi_rd,
  output rsel_e             rsel
);

  logic acc_wr;
  logic acc_rd;

  assign acc_wr = psel & penable & pwrite;
  assign acc_rd = psel & penable & ~pwrite;

  // only the two writable registers decode on writes
  assign wr_load = acc_wr & (paddr == ADDR_W'(OFS_LOAD));
  assign wr_ctl  = acc_wr & (paddr == ADDR_W'(OFS_CTL));

  // both clear locations share one strobe
  assign eoi_rd  = acc_rd & ((paddr == ADDR_W'(OFS_EOI)) |
                             (paddr == ADDR_W'(OFS_GEOI)));

  always_comb begin
    rsel = RS_ZERO;
    if (paddr == ADDR_W'(OFS_LOAD))        rsel = RS_LOAD;
    else if (paddr == ADDR_W'(OFS_CUR))    rsel = RS_CUR;
    else if (paddr == ADDR_W'(OFS_CTL))    rsel = RS_CTL;
    else if (paddr == ADDR_W'(OFS_STAT))   rsel = RS_MSTAT;
    else if (paddr == ADDR_W'(OFS_GSTAT))  rsel = RS_MSTAT;
    else if (paddr == ADDR_W'(OFS_GRAW))   rsel = RS_RAW;
    else if (paddr == ADDR_W'(OFS_VER))    rsel = RS_VER;
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output ctl_t              ctl_q,
  output logic              start
);

  logic [DATA_W-1:0] load_d;
  ctl_t              ctl_d;
  ctl_t              ctl_wr;

  assign ctl_wr = ctl_t'(wdata[CTL_W-1:0]);

  always_comb begin
    load_d = load_q;
    ctl_d  = ctl_q;
    if (wr_load) load_d = wdata;
    if (wr_ctl)  ctl_d  = ctl_wr;
  end

  // a rising enable copies the load value on the same edge
  assign start = wr_ctl & wdata[CB_EN] & ~ctl_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_load) load_q <= load_d;
      if (wr_ctl)  ctl_q  <= ctl_d;
    end
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              periodic,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  output logic [DATA_W-1:0] cnt_q,
  output logic              tc
);

  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
  localparam logic [DATA_W-1:0] ALLONES = '1;

  logic [DATA_W-1:0] cnt_d;
  logic [DATA_W-1:0] reload;
  logic              cnt_ce;

  assign reload = periodic ? load : ALLONES;
  assign cnt_ce = start | en;

  always_comb begin
    cnt_d = cnt_q;
    tc    = 1'b0;
    if (start) begin
      cnt_d = load;
    end else if (en) begin
      if (cnt_q == '0) begin
        cnt_d = reload;
      end else begin
        cnt_d = cnt_q - ONE;
        tc    = (cnt_q == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  input  logic clr,
  input  logic msk,
  output logic raw_q,
  output logic pend
);

  logic raw_d;

  // a new terminal step outranks a clear on the same edge
  always_comb begin
    raw_d = raw_q;
    if (clr) raw_d = 1'b0;
    if (tc)  raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end

  assign pend = raw_q & ~msk;

endmodule

// File: rtl/apb_cdtimer.sv
module apb_cdtimer
  import tmr_pkg::*;
#(
  parameter int unsigned        DATA_W  = 32,
  parameter int unsigned        ADDR_W  = 8,
  parameter logic [DATA_W-1:0]  VERSION = DATA_W'(32'h0001_0002)
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq
);

  logic              wr_load;
  logic              wr_ctl;
  logic              eoi_rd;
  rsel_e             rsel;
  logic [DATA_W-1:0] ld_q;
  ctl_t              ctl_q;
  logic              start;
  logic [DATA_W-1:0] cnt_q;
  logic              tc;
  logic              raw_q;
  logic              pend;
  logic              ctl_en;
  logic              ctl_per;
  logic              ctl_msk;

  assign ctl_en  = ctl_q.en;
  assign ctl_per = ctl_q.per;
  assign ctl_msk = ctl_q.msk;

  tmr_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wr_load (wr_load),
    .wr_ctl  (wr_ctl),
    .eoi_rd  (eoi_rd),
    .rsel    (rsel)
  );

  tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_load (wr_load),
    .wr_ctl  (wr_ctl),
    .wdata   (pwdata),
    .load_q  (ld_q),
    .ctl_q   (ctl_q),
    .start   (start)
  );

  tmr_count #(.DATA_W(DATA_W)) u_cnt (
    .clk      (pclk),
    .rst_n    (presetn),
    .en       (ctl_en),
    .periodic (ctl_per),
    .start    (start),
    .load     (ld_q),
    .cnt_q    (cnt_q),
    .tc       (tc)
  );

  tmr_irq u_irq (
    .clk   (pclk),
    .rst_n (presetn),
    .tc    (tc),
    .clr   (eoi_rd),
    .msk   (ctl_msk),
    .raw_q (raw_q),
    .pend  (pend)
  );

  always_comb begin
    unique case (rsel)
      RS_LOAD:  prdata = ld_q;
      RS_CUR:   prdata = cnt_q;
      RS_CTL:   prdata = DATA_W'(ctl_q);
      RS_MSTAT: prdata = DATA_W'(pend);
      RS_RAW:   prdata = DATA_W'(raw_q);
      RS_VER:   prdata = VERSION;
      default:  prdata = '0;
    endcase
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq     = pend;

endmodule

// File: rtl/apb_cdtimer_chk.sv
module tmr_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] ld,
  input logic              en,
  input logic              per,
  input logic              msk,
  input logic              raw
);

  logic ctl_touch;
  logic clr_rd;

  assign ctl_touch = psel & penable & pwrite & (paddr == ADDR_W'(8'h08));
  assign clr_rd    = psel & penable & ~pwrite &
                     ((paddr == ADDR_W'(8'h0C)) | (paddr == ADDR_W'(8'hA4)));

  AST_DECREMENT: assert property (@(posedge pclk) disable iff (!presetn)
    (en && !ctl_touch && cnt != '0) |=> (cnt == $past(cnt) - DATA_W'(1))); // R3

  AST_HOLD_WHEN_OFF: assert property (@(posedge pclk) disable iff (!presetn)
    (!en && !ctl_touch) |=> ($stable(cnt) && !$rose(raw))); // R4

  AST_RAW_SOURCE: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(raw) |-> ($past(en) && $past(cnt) == DATA_W'(1))); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge pclk) disable iff (!presetn)
    (en && per && !ctl_touch && cnt == '0) |=> (cnt == $past(ld))); // R6

  AST_FREE_RELOAD: assert property (@(posedge pclk) disable iff (!presetn)
    (en && !per && !ctl_touch && cnt == '0) |=> (cnt == '1)); // R7

  AST_EOI_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    (clr_rd && !(en && cnt == DATA_W'(1))) |=> !raw); // R8

  AST_MASK_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    msk |-> !irq); // R9

endmodule

bind apb_cdtimer tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .irq     (irq),
  .cnt     (cnt_q),
  .ld      (ld_q),
  .en      (ctl_en),
  .per     (ctl_per),
  .msk     (ctl_msk),
  .raw     (raw_q)
);

// File: tb/apb_cdtimer_bench.sv
`timescale 1ns/1ps
module apb_cdtimer_bench;

  localparam logic [31:0] VER = 32'h5645_5231;

  logic        clk;
  logic        presetn;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        irq;

  int unsigned cyc;
  int unsigned acc_cyc;
  int          n_chk;
  int          n_bad;
  bit          done;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  apb_cdtimer #(.DATA_W(32), .ADDR_W(8), .VERSION(VER)) u_apb_cdtimer (
    .pclk    (clk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every read access phase
  always @(negedge clk) begin
    if (presetn && psel && penable && !pwrite) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read got %h expected none", prdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (prdata !== e) begin
          n_bad++;
          $display("FAIL %s: prdata %h expected %h", t, prdata, e);
        end
      end
    end
  end

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    acc_cyc = cyc;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic apb_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus(1'b0, a, '0);
  endtask

  task automatic wait_cyc(input int unsigned n);
    while (cyc < n) begin
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [31:0] exp_per(input int unsigned l, input int unsigned e);
    return 32'(l - (e % (l + 1)));
  endfunction

  function automatic logic [31:0] exp_free(input int unsigned l, input int unsigned e);
    if (e <= l) return 32'(l - e);
    return 32'hFFFF_FFFF - 32'(e - l - 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned cw;
    int unsigned cd;
    int unsigned l;
    n_chk = 0; n_bad = 0; done = 1'b0;
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    repeat (4) @(posedge clk);
    #1;
    check({31'b0, irq}, 32'd0, "R1 irq in reset");
    check({30'b0, pready, pslverr}, 32'd2, "R11 bus response in reset");
    presetn = 1'b1;

    // R1 reset values
    apb_rd(8'h00, 32'd0, "R1 load");
    apb_rd(8'h04, 32'd0, "R1 current");
    apb_rd(8'h08, 32'd0, "R1 control");
    apb_rd(8'hA8, 32'd0, "R1 raw");

    // R2 map and readback
    apb_wr(8'h00, 32'hDEAD_BEEF);
    apb_rd(8'h00, 32'hDEAD_BEEF, "R2 load readback");
    apb_wr(8'h08, 32'hFFFF_FFF4);
    apb_rd(8'h08, 32'h0000_0004, "R2 control width");
    apb_rd(8'hAC, VER, "R2 version");
    apb_rd(8'h14, 32'd0, "R2 unmapped 0x14");
    apb_rd(8'h9C, 32'd0, "R2 unmapped 0x9C");

    // R10 read-only offsets ignore writes
    apb_wr(8'h04, 32'h0000_1234);
    apb_rd(8'h04, 32'd0, "R10 current not writable");
    apb_wr(8'hA8, 32'd1);
    apb_rd(8'hA8, 32'd0, "R10 raw not writable");
    apb_wr(8'hAC, 32'd0);
    apb_rd(8'hAC, VER, "R10 version not writable");
    apb_rd(8'h00, 32'hDEAD_BEEF, "R10 load untouched");

    // periodic run, load 20
    l = 20;
    apb_wr(8'h08, 32'd0);
    apb_wr(8'h00, 32'(l));
    apb_wr(8'h08, 32'd3);
    cw = acc_cyc;
    wait_cyc(cw + l - 1);
    check({31'b0, irq}, 32'd0, "R5 no irq before terminal step");
    wait_cyc(cw + l);
    check({31'b0, irq}, 32'd1, "R5 irq on terminal step");
    apb_rd(8'h0C, 32'd0, "R8 eoi read value");
    check({31'b0, irq}, 32'd0, "R8 irq cleared by eoi");
    apb_rd(8'hA8, 32'd0, "R8 raw cleared");
    wait_cyc(cw + 2 * l);
    check({31'b0, irq}, 32'd0, "R6 no irq before second period");
    wait_cyc(cw + 2 * l + 1);
    check({31'b0, irq}, 32'd1, "R6 irq after load+1 cycles");
    apb_wr(8'h08, 32'd2);
    cd = acc_cyc;
    apb_rd(8'h04, exp_per(l, cd - cw), "R3 R6 count at stop");
    apb_rd(8'hA8, 32'd1, "R4 pending kept after disable");
    repeat (10) @(posedge clk);
    apb_rd(8'h04, exp_per(l, cd - cw), "R4 count held while off");
    apb_rd(8'hA4, 32'd0, "R8 global eoi value");
    apb_rd(8'hA8, 32'd0, "R8 global eoi clears");
    repeat (30) @(posedge clk);
    #1;
    check({31'b0, irq}, 32'd0, "R4 no new irq while off");

    // mask, load 5
    apb_wr(8'h00, 32'd5);
    apb_wr(8'h08, 32'd7);
    cw = acc_cyc;
    wait_cyc(cw + 6);
    check({31'b0, irq}, 32'd0, "R9 masked irq low");
    apb_rd(8'hA8, 32'd1, "R5 raw set under mask");
    apb_rd(8'h10, 32'd0, "R9 masked status");
    apb_rd(8'hA0, 32'd0, "R9 global masked status");
    apb_wr(8'h08, 32'd3);
    check({31'b0, irq}, 32'd1, "R9 irq after unmask");
    apb_rd(8'h10, 32'd1, "R9 status after unmask");
    apb_rd(8'hA0, 32'd1, "R9 global status after unmask");
    apb_wr(8'h08, 32'd0);
    apb_rd(8'h0C, 32'd0, "R8 eoi");
    check({31'b0, irq}, 32'd0, "R8 irq low after eoi");

    // free-running, load 8
    l = 8;
    apb_wr(8'h00, 32'(l));
    apb_wr(8'h08, 32'd1);
    cw = acc_cyc;
    wait_cyc(cw + 14);
    apb_wr(8'h08, 32'd0);
    cd = acc_cyc;
    apb_rd(8'h04, exp_free(l, cd - cw), "R7 count after all-ones reload");
    apb_rd(8'hA8, 32'd1, "R5 raw in free mode");
    apb_rd(8'h0C, 32'd0, "R8 eoi");

    // clear and terminal step on the same edge
    l = 10;
    apb_wr(8'h00, 32'(l));
    apb_wr(8'h08, 32'd3);
    cw = acc_cyc;
    wait_cyc(cw + l);
    check({31'b0, irq}, 32'd1, "R6 first event");
    wait_cyc(cw + 2 * l - 2);
    apb_rd(8'h0C, 32'd0, "R8 colliding eoi value");
    check(acc_cyc, cw + 2 * l + 1, "R8 collision timing");
    check({31'b0, irq}, 32'd1, "R8 set wins over clear");
    apb_rd(8'h0C, 32'd0, "R8 eoi");
    check({31'b0, irq}, 32'd0, "R8 plain clear");
    apb_wr(8'h08, 32'd0);

    check({30'b0, pready, pslverr}, 32'd2, "R11 bus response");
    repeat (3) @(posedge clk);
    check(32'(exp_q.size()), 32'd0, "scoreboard drained");
    finish_run();
  end

endmodule